// File: doc/BRIEF.md
# Pulse-Swallow Divider Controller

This block sequences the counters of a dual-modulus synthesizer divider. It runs on the output clock of a 64/65 prescaler. At the boundary of every division cycle it takes a main count M and a swallow count A from one of two programming words: a receive word and a transmit word. A select input picks the word. While the swallow count is still running, the modulus-control output asks the prescaler to divide by 65. For the rest of the cycle the prescaler divides by 64. The loop therefore divides the VCO input by 64*M + A.

Division never stops for programming. Loading new words or moving the select line has no effect on the cycle in progress. The change is picked up on the edge that closes the current cycle. At the end of each division cycle, a pulse one prescaler clock wide marks the terminal count. The reload happens on the edge that ends that pulse. The reset input is asynchronous and active low, and its release is synchronised inside the block. After reset, the first cycle always takes its counts from the receive word.

Top module: `psw_divider_ctrl`

## Requirements
- R1: While `rst_n` is low, `mod_hi` and `div_pulse` are both 0.
- R2: After `rst_n` rises, the first division cycle starts on the third rising clock edge. Its counts come from `rx_word` whatever the value of `sel_tx`. Both outputs stay 0 until that edge.
- R3: In a division cycle of M clocks with swallow count A, `mod_hi` is 1 for the first A clocks and 0 for the remaining M-A clocks. With A = 0 it stays 0 for the whole cycle.
- R4: `div_pulse` is 1 only on the last clock of each division cycle, for exactly one clock. The next cycle begins on the rising edge that ends the pulse.
- R5: If each clock with `mod_hi` = 1 stands for 65 prescaler input periods and each clock with `mod_hi` = 0 stands for 64, one division cycle spans 64*M + A input periods.
- R6: `sel_tx` = 1 selects `tx_word` and `sel_tx` = 0 selects `rx_word`. The select is sampled only on the rising edge that ends a cycle, so it takes effect from the following cycle.
- R7: A change to either word during a cycle does not alter that cycle. The new value is used from the next cycle on.
- R8: Word layout: bits [SWAL_W-1:0] hold A and bits [SWAL_W+MAIN_W-1:SWAL_W] hold M. If A is greater than M, A is taken as M.
- R9: A main count of 0 is taken as 1. The cycle is then one clock long and `div_pulse` is 1 on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| presc_clk | input | 1 | Prescaler output clock; one rising edge per prescaler period |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised internally |
| rx_word | input | MAIN_W+SWAL_W | Receive programming word {M, A} |
| tx_word | input | MAIN_W+SWAL_W | Transmit programming word {M, A} |
| sel_tx | input | 1 | Word select: 1 transmit, 0 receive, sampled at cycle boundaries |
| mod_hi | output | 1 | Modulus control: 1 requests divide-by-65, 0 divide-by-64 |
| div_pulse | output | 1 | One-clock pulse on the last clock of each division cycle |

## Verification
The bench builds the block with a 7-bit swallow field and an 8-bit main field. Every main count from 0 to 255 can therefore be reached in a short run, including the zero substitution and the one-clock cycle that results from it. The swallow field reaches 127, which exceeds most of the main counts drawn, so the clamp is exercised often. With the narrow main field, the full-scale cycle of 255 clocks fits many times within the run, alongside the reset-release alignment and the mid-cycle changes to the words and the select.

// File: rtl/psw_pkg.sv
package psw_pkg;

  // Controller phase: waiting for the first load after reset, or dividing.
  typedef enum logic {
    PSW_HOLD = 1'b0,
    PSW_RUN  = 1'b1
  } psw_phase_e;

  // Flops in the reset release synchroniser.
  localparam int PSW_SYNC_STAGES = 2;

endpackage

// File: rtl/psw_rst_sync.sv
module psw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sn = sync_q[STAGES-1];

endmodule

// File: rtl/psw_word_pick.sv
module psw_word_pick #(
  parameter int MAIN_W = 11,
  parameter int SWAL_W = 7
) (
  input  logic [MAIN_W+SWAL_W-1:0] rx_word,
  input  logic [MAIN_W+SWAL_W-1:0] tx_word,
  input  logic                     sel_tx,
  input  logic                     force_rx,
  output logic [MAIN_W-1:0]        main_eff,
  output logic [SWAL_W-1:0]        swal_eff
);

  localparam int WORD_W = MAIN_W + SWAL_W;
  localparam int NWORDS = 2;

  logic [WORD_W-1:0] word_arr [NWORDS];
  logic [MAIN_W-1:0] main_f   [NWORDS];
  logic [SWAL_W-1:0] swal_f   [NWORDS];
  logic              pick_tx;
  logic [MAIN_W-1:0] main_raw;
  logic [SWAL_W-1:0] swal_raw;

  assign word_arr[0] = rx_word;
  assign word_arr[1] = tx_word;

  for (genvar gi = 0; gi < NWORDS; gi++) begin : g_unpack
    assign swal_f[gi] = word_arr[gi][SWAL_W-1:0];
    assign main_f[gi] = word_arr[gi][WORD_W-1:SWAL_W];
  end

  always_comb begin
    pick_tx  = sel_tx && !force_rx;
    main_raw = pick_tx ? main_f[1] : main_f[0];
    swal_raw = pick_tx ? swal_f[1] : swal_f[0];
    main_eff = (main_raw == '0) ? MAIN_W'(1) : main_raw;
  end

  // Clamp A to M, compared at the wider of the two field widths.
  if (MAIN_W >= SWAL_W) begin : g_cmp_main
    logic [MAIN_W-1:0] swal_ext;
    always_comb begin
      swal_ext = MAIN_W'(swal_raw);
      swal_eff = (swal_ext > main_eff) ? SWAL_W'(main_eff) : swal_raw;
    end
  end else begin : g_cmp_swal
    logic [SWAL_W-1:0] main_ext;
    always_comb begin
      main_ext = SWAL_W'(main_eff);
      swal_eff = (swal_raw > main_ext) ? main_ext : swal_raw;
    end
  end

endmodule

// File: rtl/psw_count_core.sv
module psw_count_core
  import psw_pkg::*;
#(
  parameter int MAIN_W = 11,
  parameter int SWAL_W = 7
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic [MAIN_W-1:0] main_ld,
  input  logic [SWAL_W-1:0] swal_ld,
  output logic              use_rx,
  output logic              running,
  output logic [MAIN_W-1:0] main_cnt,
  output logic [SWAL_W-1:0] swal_cnt,
  output logic              mod_hi,
  output logic              div_pulse
);

  psw_phase_e        phase_q, phase_d;
  logic [MAIN_W-1:0] main_q, main_d;
  logic [SWAL_W-1:0] swal_q, swal_d;
  logic              term_hit;
  logic              reload;
  logic              main_en;
  logic              swal_en;

  // Next-state logic
  always_comb begin
    term_hit = (phase_q == PSW_RUN) && (main_q == '0);
    reload   = (phase_q == PSW_HOLD) || term_hit;
    main_en  = (phase_q == PSW_RUN) || reload;
    swal_en  = reload || (swal_q != '0);
    phase_d  = PSW_RUN;
    if (reload) begin
      main_d = main_ld - 1'b1;
      swal_d = swal_ld;
    end else begin
      main_d = main_q - 1'b1;
      swal_d = swal_q - 1'b1;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      phase_q <= PSW_HOLD;
    end else begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      main_q <= '0;
    end else if (main_en) begin
      main_q <= main_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      swal_q <= '0;
    end else if (swal_en) begin
      swal_q <= swal_d;
    end
  end

  // Output decode
  always_comb begin
    use_rx    = (phase_q == PSW_HOLD);
    running   = (phase_q == PSW_RUN);
    mod_hi    = (phase_q == PSW_RUN) && (swal_q != '0);
    div_pulse = term_hit;
    main_cnt  = main_q;
    swal_cnt  = swal_q;
  end

endmodule

// File: rtl/psw_divider_ctrl.sv
module psw_divider_ctrl
  import psw_pkg::*;
#(
  parameter int MAIN_W = 11,
  parameter int SWAL_W = 7
) (
  input  logic                     presc_clk,
  input  logic                     rst_n,
  input  logic [MAIN_W+SWAL_W-1:0] rx_word,
  input  logic [MAIN_W+SWAL_W-1:0] tx_word,
  input  logic                     sel_tx,
  output logic                     mod_hi,
  output logic                     div_pulse
);

  logic              rst_sn;
  logic              use_rx;
  logic              running;
  logic [MAIN_W-1:0] main_eff;
  logic [SWAL_W-1:0] swal_eff;
  logic [MAIN_W-1:0] main_cnt;
  logic [SWAL_W-1:0] swal_cnt;

  psw_rst_sync #(
    .STAGES (PSW_SYNC_STAGES)
  ) rst_sync_i (
    .clk    (presc_clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  psw_word_pick #(
    .MAIN_W (MAIN_W),
    .SWAL_W (SWAL_W)
  ) pick_i (
    .rx_word  (rx_word),
    .tx_word  (tx_word),
    .sel_tx   (sel_tx),
    .force_rx (use_rx),
    .main_eff (main_eff),
    .swal_eff (swal_eff)
  );

  psw_count_core #(
    .MAIN_W (MAIN_W),
    .SWAL_W (SWAL_W)
  ) core_i (
    .clk       (presc_clk),
    .rst_sn    (rst_sn),
    .main_ld   (main_eff),
    .swal_ld   (swal_eff),
    .use_rx    (use_rx),
    .running   (running),
    .main_cnt  (main_cnt),
    .swal_cnt  (swal_cnt),
    .mod_hi    (mod_hi),
    .div_pulse (div_pulse)
  );

endmodule

// File: rtl/psw_divider_ctrl_chk.sv
module psw_divider_ctrl_chk #(
  parameter int MAIN_W = 11,
  parameter int SWAL_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mod_hi,
  input logic              div_pulse,
  input logic              running,
  input logic [MAIN_W-1:0] main_cnt,
  input logic [SWAL_W-1:0] swal_cnt
);

  // R1: outputs quiet while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!mod_hi && !div_pulse)
        else $error("outputs active during reset");
    end
  end

  // R3: once modulus control drops inside a cycle it stays low
  assert_swallow_stays_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !mod_hi && !div_pulse) |=> !mod_hi);

  // R4: modulus control can only rise at the start of a cycle
  assert_rise_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_hi) |-> ($past(div_pulse) || $rose(running)));

  // R7: no reload partway through a cycle
  assert_no_midcycle_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !div_pulse) |=> (int'(main_cnt) + 1 == int'($past(main_cnt))));

  // R8: remaining swallow count never exceeds remaining cycle length
  assert_swallow_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (int'(swal_cnt) <= int'(main_cnt) + 1));

endmodule

bind psw_divider_ctrl psw_divider_ctrl_chk #(
  .MAIN_W (MAIN_W),
  .SWAL_W (SWAL_W)
) chk_i (
  .clk       (presc_clk),
  .rst_n     (rst_n),
  .mod_hi    (mod_hi),
  .div_pulse (div_pulse),
  .running   (running),
  .main_cnt  (main_cnt),
  .swal_cnt  (swal_cnt)
);

// File: tb/psw_divider_ctrl_tb_top.sv
module psw_divider_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MAIN_W     = 8;
  localparam int SWAL_W     = 7;
  localparam int WORD_W     = MAIN_W + SWAL_W;
  localparam int WD_CYCLES  = 150000;

  logic              clk;
  logic              rst_n;
  logic [WORD_W-1:0] rx_word;
  logic [WORD_W-1:0] tx_word;
  logic              sel_tx;
  logic              mod_hi;
  logic              div_pulse;

  int n_chk;
  int n_fail;

  // Reference model state
  int m_cur, a_cur, k, rel_cnt;
  bit m_run;
  // Observed cycle statistics
  int len_acc, hi_acc, in_acc;
  int len_last, hi_last, cyc_count;

  psw_divider_ctrl #(
    .MAIN_W (MAIN_W),
    .SWAL_W (SWAL_W)
  ) dut_i (
    .presc_clk (clk),
    .rst_n     (rst_n),
    .rx_word   (rx_word),
    .tx_word   (tx_word),
    .sel_tx    (sel_tx),
    .mod_hi    (mod_hi),
    .div_pulse (div_pulse)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [WORD_W-1:0] mk_word(input int m, input int a);
    logic [MAIN_W-1:0] mf;
    logic [SWAL_W-1:0] af;
    mf = MAIN_W'(m);
    af = SWAL_W'(a);
    return {mf, af};
  endfunction

  function automatic int eff_main(input logic [WORD_W-1:0] w);
    int m;
    m = int'(w[WORD_W-1:SWAL_W]);
    return (m == 0) ? 1 : m;
  endfunction

  function automatic int eff_swal(input logic [WORD_W-1:0] w);
    int a, m;
    a = int'(w[SWAL_W-1:0]);
    m = eff_main(w);
    return (a > m) ? m : a;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  // Reference model: advances on each rising edge from bench-driven inputs only
  always @(posedge clk) begin
    logic [WORD_W-1:0] w;
    if (!rst_n) begin
      m_run   = 1'b0;
      rel_cnt = 0;
      k       = 0;
    end else if (rel_cnt < 2) begin
      rel_cnt++;
    end else if (!m_run || k == m_cur - 1) begin
      w     = (m_run && sel_tx) ? tx_word : rx_word;
      m_cur = eff_main(w);
      a_cur = eff_swal(w);
      k     = 0;
      m_run = 1'b1;
    end else begin
      k++;
    end
  end

  // Output monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(!mod_hi && !div_pulse, "R1", "outputs in reset", int'({mod_hi, div_pulse}), 0);
      len_acc = 0; hi_acc = 0; in_acc = 0;
    end else if (!m_run) begin
      chk(!mod_hi && !div_pulse, "R2", "outputs before first load", int'({mod_hi, div_pulse}), 0);
    end else begin
      chk(mod_hi == (k < a_cur), "R3", "mod_hi", int'(mod_hi), int'(k < a_cur));
      chk(div_pulse == (k == m_cur - 1), "R4", "div_pulse", int'(div_pulse), int'(k == m_cur - 1));
      len_acc++;
      hi_acc += int'(mod_hi);
      in_acc += 64 + int'(mod_hi);
      if (div_pulse) begin
        chk(in_acc == 64 * m_cur + a_cur, "R5", "input periods per cycle", in_acc, 64 * m_cur + a_cur);
        len_last = len_acc;
        hi_last  = hi_acc;
        cyc_count++;
        len_acc = 0; hi_acc = 0; in_acc = 0;
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_cycles(input int n);
    int target;
    target = cyc_count + n;
    while (cyc_count < target) step();
  endtask

  task automatic chk_cycle(input string tag, input int exp_len, input int exp_hi);
    chk(len_last == exp_len, tag, "cycle length", len_last, exp_len);
    chk(hi_last == exp_hi, tag, "divide-by-65 clocks", hi_last, exp_hi);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R4 watchdog: cycles=%0d expected below %0d", WD_CYCLES, WD_CYCLES);
    finish_run();
  end

  initial begin
    int seed_dummy;
    n_chk = 0; n_fail = 0; cyc_count = 0; len_last = 0; hi_last = 0;
    len_acc = 0; hi_acc = 0; in_acc = 0;
    m_run = 1'b0; rel_cnt = 0; k = 0; m_cur = 1; a_cur = 0;
    seed_dummy = $urandom(32'h5eed);
    rst_n   = 1'b0;
    rx_word = mk_word(5, 2);
    tx_word = mk_word(9, 3);
    sel_tx  = 1'b1;
    repeat (3) step();
    chk(!mod_hi && !div_pulse, "R1", "idle in reset", int'({mod_hi, div_pulse}), 0);

    // R2: first cycle from receive word although transmit is selected
    rst_n = 1'b1;
    wait_cycles(1);
    chk_cycle("R2", 5, 2);
    // R6: select high picks transmit word from the next cycle
    wait_cycles(1);
    chk_cycle("R6", 9, 3);
    // R7: transmit word changed partway through a cycle
    step(); step();
    tx_word = mk_word(4, 1);
    wait_cycles(1);
    chk_cycle("R7", 9, 3);
    wait_cycles(1);
    chk_cycle("R7", 4, 1);
    // R6: select low picks receive word
    sel_tx = 1'b0;
    wait_cycles(1);
    chk_cycle("R6", 5, 2);
    // R8: swallow larger than main is clamped
    rx_word = mk_word(3, 7);
    wait_cycles(1);
    chk_cycle("R8", 3, 3);
    // R9: main of zero acts as one
    rx_word = mk_word(0, 4);
    wait_cycles(1);
    chk_cycle("R9", 1, 1);
    wait_cycles(1);
    chk_cycle("R9", 1, 1);
    // R3: zero swallow keeps divide-by-64 throughout
    rx_word = mk_word(6, 0);
    wait_cycles(1);
    chk_cycle("R3", 6, 0);
    // R5: full-scale cycle
    rx_word = mk_word(255, 127);
    wait_cycles(1);
    chk_cycle("R5", 255, 127);

    // Random stimulus with changes at arbitrary points
    for (int it = 0; it < 400; it++) begin
      int m, a, pick;
      m = ($urandom_range(0, 9) < 7) ? int'($urandom_range(0, 12)) : int'($urandom_range(0, 255));
      a = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 127)) : int'($urandom_range(0, m));
      pick = int'($urandom_range(0, 2));
      if (pick == 0) rx_word = mk_word(m, a);
      else if (pick == 1) tx_word = mk_word(m, a);
      else sel_tx = ~sel_tx;
      repeat ($urandom_range(1, 25)) step();
    end

    // R1/R2: reset in the middle of a cycle
    rx_word = mk_word(7, 3);
    tx_word = mk_word(11, 5);
    sel_tx  = 1'b1;
    rst_n   = 1'b0;
    step();
    chk(!mod_hi && !div_pulse, "R1", "async clear mid-cycle", int'({mod_hi, div_pulse}), 0);
    step();
    rst_n = 1'b1;
    wait_cycles(1);
    chk_cycle("R2", 7, 3);
    wait_cycles(1);
    chk_cycle("R6", 11, 5);

    finish_run();
  end

endmodule